// File: doc/BRIEF.md
# Programmable Up-Counting Interval Timer

This block is a single 32-bit interval timer. It counts upward one step per clock from a loadable starting value toward a programmable limit. When the count meets the limit, the timer does two things. It rolls back to zero on the following tick, and it can latch a level interrupt. Because the counter rolls over by itself, a periodic event source needs no reload from software.

A one-shot event is armed in three writes: load the limit, write zero to the count, then write the control register with the run and enable bits set. Any later write to the control register acknowledges the interrupt, whatever data it carries. With the limit left at all-ones and the enable bit clear, the block serves as a free-running wrapping cycle counter.

Three registers sit on a simple bus with an address, a write strobe, write data and combinational read data.

Top module: `interval_timer`

## Requirements
- R1: After reset the count reads 0, the limit reads 0xFFFFFFFF, the control register reads 0 and the interrupt output is low.
- R2: While control bit 1 (run) is set, the count rises by exactly one per clock; while it is clear, the count holds its value.
- R3: A write to address 0 loads the count with the write data on that edge, replacing any increment in that cycle.
- R4: A running count that equals the limit becomes 0 on the next edge.
- R5: A limit match while control bit 0 (interrupt enable) is set drives the interrupt output high from the next edge. Control bit 3 then reads 1.
- R6: A limit match while control bit 0 is clear leaves the interrupt output low.
- R7: Any write to address 2 (control) clears the interrupt output on that edge, whatever value is written.
- R8: When a control write and an enabled limit match fall in the same cycle, the interrupt output ends up low.
- R9: Once raised, the interrupt output stays high until a control write, even while the count keeps running.
- R10: With the limit at 0xFFFFFFFF, a running count steps from 0xFFFFFFFF to 0 and continues counting.
- R11: Reads return the count at address 0, the limit at address 1, and the control word at address 2. The control word holds enable in bit 0, run in bit 1 and pending in bit 3; every other bit reads 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select: 0 count, 1 limit, 2 control |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Level interrupt, high while an event is pending |

## Verification
On every cycle, the assertions check the following:
- The count holds while halted, steps by one while running below the limit, and returns to zero after a match.
- The interrupt rises only after an enabled match, stays high until acknowledged, and is low after any control write.

Some behaviour only the directed scenarios can show:
- The register readback layout, including the pending bit and the unused address.
- The reset values.
- Same-cycle cases: a count load overriding a tick, and an acknowledge beating a match.
- The all-ones wrap of the free-running mode.

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int DW = 32,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam logic [AW-1:0] A_CNT  = AW'(0);
  localparam logic [AW-1:0] A_LIM  = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [DW-1:0] ONES   = {DW{1'b1}};

  logic [DW-1:0] count_q, limit_q;
  logic          ie_q, run_q, pend_q;

  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire wr_lim  = bus_wr && bus_addr == A_LIM;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire at_lim  = count_q == limit_q;
  wire tick    = run_q && !wr_cnt;
  wire hit     = tick && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      limit_q <= ONES;
      ie_q    <= 1'b0;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (wr_cnt)      count_q <= bus_wdata;
      else if (hit)    count_q <= '0;
      else if (tick)   count_q <= count_q + 1'b1;
      if (wr_lim)      limit_q <= bus_wdata;
      if (wr_ctrl) begin
        ie_q   <= bus_wdata[0];
        run_q  <= bus_wdata[1];
        pend_q <= 1'b0;
      end else if (hit && ie_q) begin
        pend_q <= 1'b1;
      end
    end
  end

  assign irq = pend_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT:   bus_rdata = count_q;
      A_LIM:   bus_rdata = limit_q;
      A_CTRL:  begin
        bus_rdata[0] = ie_q;
        bus_rdata[1] = run_q;
        bus_rdata[3] = pend_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr_cnt) |=> $stable(count_q));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_cnt && !at_lim) |=> count_q == $past(count_q) + 1'b1);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !wr_cnt && at_lim) |=> count_q == '0);

  p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ie_q && run_q && at_lim));

  p_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !irq);

  p_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctrl) |=> irq);
endmodule

// File: tb/interval_timer_test.sv
module interval_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  interval_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); check("R1 count", v, 0);
    rd(1, v); check("R1 limit", v, 32'hFFFF_FFFF);
    rd(2, v); check("R1 ctrl", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    rd(3, v); check("R11 addr3", v, 0);
  endtask

  task automatic t_run_hold;
    logic [31:0] v;
    wr(2, 0); wr(0, 7); ticks(3);
    rd(0, v); check("R2 halted hold", v, 7);
    wr(0, 10); wr(2, 2); ticks(4);
    rd(0, v); check("R2 run step", v, 14);
    wr(0, 100);
    rd(0, v); check("R3 load overrides tick", v, 100);
    ticks(1); rd(0, v); check("R2 after load", v, 101);
    wr(2, 0);
  endtask

  task automatic t_oneshot;
    logic [31:0] v;
    wr(1, 5); wr(0, 0); wr(2, 3); ticks(5);
    rd(0, v); check("R5 at limit no irq yet", {v[30:0], irq}, {31'd5, 1'b0});
    ticks(1);
    check("R5 irq raised", {31'd0, irq}, 1);
    rd(0, v); check("R4 wrap to zero", v, 0);
    rd(2, v); check("R11 R5 ctrl pending", v, 32'hB);
    ticks(3); check("R9 irq held", {31'd0, irq}, 1);
    wr(2, 32'hFFFF_FFF3);
    check("R7 ack any data", {31'd0, irq}, 0);
    rd(2, v); check("R11 ctrl bits", v, 3);
    wr(2, 0);
  endtask

  task automatic t_same_cycle;
    wr(1, 3); wr(0, 0); wr(2, 3); ticks(3);
    wr(2, 3);
    check("R8 clear beats set", {31'd0, irq}, 0);
    ticks(4);
    check("R5 periodic next event", {31'd0, irq}, 1);
    wr(2, 0);
    check("R7 ack with zero", {31'd0, irq}, 0);
  endtask

  task automatic t_no_ie;
    logic [31:0] v;
    wr(1, 2); wr(0, 0); wr(2, 2); ticks(3);
    check("R6 no irq when disabled", {31'd0, irq}, 0);
    rd(0, v); check("R6 R4 wrapped", v, 0);
    rd(2, v); check("R6 pending clear", v, 2);
    wr(2, 0);
  endtask

  task automatic t_free;
    logic [31:0] v;
    wr(1, 32'hFFFF_FFFF); wr(0, 32'hFFFF_FFFD); wr(2, 2); ticks(3);
    rd(0, v); check("R10 wrap at all-ones", v, 0);
    ticks(1); rd(0, v); check("R10 keeps counting", v, 1);
    check("R10 irq low", {31'd0, irq}, 0);
    wr(2, 0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_run_hold;
    t_oneshot;
    t_same_cycle;
    t_no_ie;
    t_free;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule